// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a set of logic functions, each written as a sum of products. Both planes are set at run time. The AND plane decides which literals each product term uses. A literal is the true or the inverted form of a logic input. The OR plane decides which product terms feed each output. Because any term can drive any number of outputs, one term can be shared instead of built twice. The default build has 4 logic inputs, 6 product terms and 3 outputs.

Configuration is written one word per clock while a load strobe is held high. The first words are literal masks, one per product term. The remaining words are connection masks, one per output. Once the last word is stored, a done flag rises. From then on the outputs follow the logic inputs with no clock in the path. Until the done flag is set, every output is held at 0. The array is loaded once after reset and can be reloaded at any time later.

Top module: `pla_array`

## Requirements
- R1: After reset, `cfg_done` is 0 and every output bit is 0, whatever the logic inputs are.
- R2: While `cfg_load` is high, one `cfg_word` is taken on each rising clock edge. Words 0 to 5 are the literal masks of terms 0 to 5. Words 6 to 8 are the connection masks of outputs 0 to 2, held in bits [5:0]. `cfg_done` reads 1 right after the edge that takes word 8.
- R3: While `cfg_done` is 0, `logic_out` is all zeros.
- R4: In a literal mask, bit 2i selects input i in true form and bit 2i+1 selects input i in inverted form. A product term is the AND of its selected literals.
- R5: A product term whose literal mask is all zeros evaluates to 1.
- R6: A product term that selects both forms of the same input evaluates to 0.
- R7: Output j is the OR of the terms whose bit is set in its connection mask, where bit t stands for term t. An output with an empty mask drives 0.
- R8: A single product term can feed several outputs at once, and each of those outputs sees its value.
- R9: Words presented after word 8 while `cfg_load` stays high are ignored and leave the stored configuration unchanged.
- R10: If `cfg_load` drops before word 8, the position returns to word 0. If a later load starts, it begins at word 0 and clears `cfg_done` on the edge that takes its first word.
- R11: While `cfg_load` is low, `cfg_done` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration strobe; while high, one word is taken per edge |
| cfg_word | input | 8 | Configuration word: a literal mask or a connection mask |
| cfg_done | output | 1 | Set when a full configuration is stored |
| logic_in | input | 4 | Logic inputs |
| logic_out | output | 3 | Sum-of-products outputs, zero until configured |

## Verification
The bound checker watches several behaviours on every cycle. It checks that the outputs stay at zero while unconfigured, and that the done flag only rises during a load and holds while the strobe is low. It checks that a new load clears the flag, that extra words never disturb the stored masks, and that all outputs are zero when no term is active. What the outputs actually compute can only be shown by the bench. It loads tabled and random masks and compares all 16 input patterns against its own model. Hand-worked corner cases cover empty terms, contradictory terms, empty connection masks and a term shared by two outputs. The bench also drives a partial load and a reload.

// File: rtl/pla_pkg.sv
// Package: sizes and derived widths shared by the logic array and its checker.
// Assumes the literal mask is at least as wide as the connection mask, so one word carries either.
package pla_pkg;
    parameter int N_IN   = 4;
    parameter int N_TERM = 6;
    parameter int N_OUT  = 3;

    localparam int LIT_W     = 2 * N_IN;
    localparam int CFG_W     = (LIT_W > N_TERM) ? LIT_W : N_TERM;
    localparam int N_WORDS   = N_TERM + N_OUT;
    localparam int PTR_W     = $clog2(N_WORDS + 1);
endpackage

// File: rtl/pla_cfg_loader.sv
// Module: configuration loader.
// Takes one word per clock while cfg_load is high and stores literal masks, then connection masks.
// Assumes a word is taken on every edge that sees cfg_load high, with no handshake.
module pla_cfg_loader #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT,
    localparam int LIT_W   = 2 * N_IN,
    localparam int CFG_W   = (LIT_W > N_TERM) ? LIT_W : N_TERM,
    localparam int N_WORDS = N_TERM + N_OUT,
    localparam int PTR_W   = $clog2(N_WORDS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_load,
    input  logic [CFG_W-1:0]                  cfg_word,
    output logic [N_TERM-1:0][LIT_W-1:0]      lit_mask,
    output logic [N_OUT-1:0][N_TERM-1:0]      conn_mask,
    output logic [PTR_W-1:0]                  word_ptr,
    output logic                              done
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(N_WORDS - 1);
    localparam logic [PTR_W-1:0] END_IDX  = PTR_W'(N_WORDS);

    logic take;

    // Purpose: a word is taken only while loading and before the sequence ends.
    always_comb begin
        take = cfg_load && (word_ptr < END_IDX);
    end

    // Purpose: advance the word position and track completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ptr <= '0;
            done     <= 1'b0;
        end else if (cfg_load) begin
            if (take) begin
                word_ptr <= word_ptr + 1'b1;
                if (word_ptr == '0)
                    done <= 1'b0;
                if (word_ptr == LAST_IDX)
                    done <= 1'b1;
            end
        end else begin
            word_ptr <= '0;
        end
    end

    genvar t;
    generate
        for (t = 0; t < N_TERM; t++) begin : g_lit
            // Purpose: store the literal mask of term t when its word arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lit_mask[t] <= '0;
                else if (take && word_ptr == PTR_W'(t))
                    lit_mask[t] <= cfg_word[LIT_W-1:0];
            end
        end
    endgenerate

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_conn
            // Purpose: store the connection mask of output o when its word arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    conn_mask[o] <= '0;
                else if (take && word_ptr == PTR_W'(N_TERM + o))
                    conn_mask[o] <= cfg_word[N_TERM-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/pla_and_plane.sv
// Module: AND plane.
// Forms every product term from the true and inverted literals that its mask selects.
// Assumes literal mask bit 2i is the true form of input i and bit 2i+1 is its inverted form.
module pla_and_plane #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]                   in_bits,
    input  logic [N_TERM-1:0][LIT_W-1:0]      lit_mask,
    output logic [N_TERM-1:0]                 terms
);
    logic [LIT_W-1:0] literals;

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_lits
            // Purpose: place each input in both of its forms.
            always_comb begin
                literals[2*i]   = in_bits[i];
                literals[2*i+1] = ~in_bits[i];
            end
        end
    endgenerate

    genvar t;
    generate
        for (t = 0; t < N_TERM; t++) begin : g_term
            // Purpose: an unselected literal counts as 1, so an empty term is 1.
            always_comb begin
                terms[t] = &(literals | ~lit_mask[t]);
            end
        end
    endgenerate
endmodule

// File: rtl/pla_or_plane.sv
// Module: OR plane.
// Each output is the OR of the product terms its connection mask selects.
// Assumes the term vector and the masks use the same bit order.
module pla_or_plane #(
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT
) (
    input  logic [N_TERM-1:0]                 terms,
    input  logic [N_OUT-1:0][N_TERM-1:0]      conn_mask,
    output logic [N_OUT-1:0]                  sums
);
    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_sum
            // Purpose: an empty mask gives 0.
            always_comb begin
                sums[o] = |(terms & conn_mask[o]);
            end
        end
    endgenerate
endmodule

// File: rtl/pla_array.sv
// Module: configurable sum-of-products array (top).
// Holds both planes in registers and computes outputs from the inputs with no clock in the path.
// Assumes the outputs may only be trusted once cfg_done is set; until then they are held at zero.
module pla_array #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT,
    localparam int LIT_W   = 2 * N_IN,
    localparam int CFG_W   = (LIT_W > N_TERM) ? LIT_W : N_TERM,
    localparam int N_WORDS = N_TERM + N_OUT,
    localparam int PTR_W   = $clog2(N_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              cfg_done,
    input  logic [N_IN-1:0]   logic_in,
    output logic [N_OUT-1:0]  logic_out
);
    logic [N_TERM-1:0][LIT_W-1:0]  lit_mask;
    logic [N_OUT-1:0][N_TERM-1:0]  conn_mask;
    logic [PTR_W-1:0]              word_ptr;
    logic [N_TERM-1:0]             term_vec;
    logic [N_OUT-1:0]              sum_vec;

    pla_cfg_loader #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_word  (cfg_word),
        .lit_mask  (lit_mask),
        .conn_mask (conn_mask),
        .word_ptr  (word_ptr),
        .done      (cfg_done)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_bits  (logic_in),
        .lit_mask (lit_mask),
        .terms    (term_vec)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .terms     (term_vec),
        .conn_mask (conn_mask),
        .sums      (sum_vec)
    );

    // Purpose: hold the outputs at zero until a full configuration is in place.
    always_comb begin
        logic_out = cfg_done ? sum_vec : '0;
    end
endmodule

// File: rtl/pla_array_chk.sv
// Module: checker for pla_array, bound to every instance.
// Assumes the names of the top's internal signals match the bind below.
module pla_array_chk #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT,
    localparam int LIT_W   = 2 * N_IN,
    localparam int N_WORDS = N_TERM + N_OUT,
    localparam int PTR_W   = $clog2(N_WORDS + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_load,
    input logic                          cfg_done,
    input logic [N_OUT-1:0]              logic_out,
    input logic [N_TERM-1:0]             term_vec,
    input logic [PTR_W-1:0]              word_ptr,
    input logic [N_TERM-1:0][LIT_W-1:0]  lit_mask,
    input logic [N_OUT-1:0][N_TERM-1:0]  conn_mask
);
    AST_ZERO_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> logic_out == '0);  // R3
    AST_DONE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_load));  // R2
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_load) |=> !cfg_done);  // R10
    AST_DONE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> cfg_done == $past(cfg_done));  // R11
    AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && word_ptr == PTR_W'(N_WORDS)) |=> ($stable(lit_mask) && $stable(conn_mask)));  // R9
    AST_NO_TERM_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (term_vec == '0) |-> logic_out == '0);  // R7
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_done  (cfg_done),
    .logic_out (logic_out),
    .term_vec  (term_vec),
    .word_ptr  (word_ptr),
    .lit_mask  (lit_mask),
    .conn_mask (conn_mask)
);

// File: tb/pla_array_bench.sv
module pla_array_bench;
    localparam int NI = 4;
    localparam int NT = 6;
    localparam int NO = 3;
    localparam int NW = NT + NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [7:0]    cfg_word = '0;
    logic          cfg_done;
    logic [NI-1:0] logic_in = '0;
    logic [NO-1:0] logic_out;

    int checks = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pla_array u_pla_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_word  (cfg_word),
        .cfg_done  (cfg_done),
        .logic_in  (logic_in),
        .logic_out (logic_out)
    );

    // Each entry holds 9 words, with word k in bits [8k+7:8k].
    localparam logic [71:0] CFG_TABLE [4] = '{
        72'h0C_06_01_0C_03_80_05_03_00,
        72'h00_00_00_FF_12_34_56_78_9A,
        72'h3F_3F_3F_00_00_00_00_00_00,
        72'h2A_15_21_A5_4B_60_91_0A_C3
    };

    function automatic logic [NO-1:0] model(input logic [71:0] cfg, input logic [NI-1:0] x);
        logic [NT-1:0] tv;
        logic [NO-1:0] r;
        for (int t = 0; t < NT; t++) begin
            logic [7:0] m;
            m = cfg[8*t +: 8];
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (m[2*i] && !x[i]) tv[t] = 1'b0;
                if (m[2*i+1] && x[i]) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < NO; o++)
            r[o] = |(tv & cfg[8*(NT+o) +: NT]);
        return r;
    endfunction

    task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load_words(input logic [71:0] cfg, input int count, input int extra);
        @(negedge clk);
        for (int k = 0; k < count + extra; k++) begin
            cfg_load = 1'b1;
            cfg_word = (k < count) ? cfg[8*k +: 8] : 8'hFF;
            @(negedge clk);
        end
        cfg_load = 1'b0;
        cfg_word = '0;
    endtask

    task automatic sweep(input logic [71:0] cfg, input string req);
        for (int v = 0; v < 16; v++) begin
            logic_in = v[NI-1:0];
            #1;
            check(req, logic_out, model(cfg, v[NI-1:0]));
        end
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic_in = 4'hF;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 done", {2'b00, cfg_done}, 3'b000);
        check("R1 out", logic_out, 3'b000);
        rst_n = 1'b1;

        // R2 R4 R7: tabled configurations against the model
        for (int c = 0; c < 4; c++) begin
            load_words(CFG_TABLE[c], NW, 0);
            check("R2 done", {2'b00, cfg_done}, 3'b001);
            sweep(CFG_TABLE[c], "R4 R7 table");
        end

        // R4: random configurations
        for (int c = 0; c < 6; c++) begin
            logic [71:0] rc;
            rc = {$urandom(), $urandom(), $urandom()};
            load_words(rc, NW, 0);
            sweep(rc, "R4 random");
        end

        // R10: partial load leaves done low, outputs zero (R3)
        load_words(CFG_TABLE[2], 5, 0);
        logic_in = 4'h0;
        #1;
        check("R10 partial done", {2'b00, cfg_done}, 3'b000);
        check("R3 partial out", logic_out, 3'b000);

        // R9: extra words after a full load are ignored
        load_words(CFG_TABLE[0], NW, 3);
        check("R9 done", {2'b00, cfg_done}, 3'b001);
        // hand values for entry 0: out0 = empty term (R5), out1 = in0&in1,
        // out2 = in0&in1 | ~in3 (R8 shared term), term1 contradictory (R6)
        logic_in = 4'b1011; #1; check("R8 R9 in=1011", logic_out, 3'b111);
        logic_in = 4'b1000; #1; check("R5 R6 in=1000", logic_out, 3'b001);
        logic_in = 4'b0000; #1; check("R5 R8 in=0000", logic_out, 3'b101);
        logic_in = 4'b0111; #1; check("R8 in=0111", logic_out, 3'b111);

        // R11: done holds while idle
        repeat (4) @(negedge clk);
        #1;
        check("R11 idle done", {2'b00, cfg_done}, 3'b001);

        // R10: new load clears done after its first word; R3 outputs zero
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_word = 8'h00;
        @(negedge clk);
        #1;
        check("R10 reload done", {2'b00, cfg_done}, 3'b000);
        check("R3 reload out", logic_out, 3'b000);
        cfg_load = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule